// File: doc/BRIEF.md
# Serial Memory Slave Controller

This block is the slave side of a four-wire serial link in front of a small byte array and a status register. A fast system clock oversamples the chip-select, serial clock, data-in, pause and write-protect pins through two-flop synchronisers. The block samples data-in on rising serial-clock edges and changes data-out after falling edges. It decodes a command byte and moves data most significant bit first. The data-out pin is driven through a separate enable, so the pad can float when the block is not talking.

A host can set and clear a write-enable latch, read the status byte and update the protection bit in the status register. It can read the array from any address, and it can buffer a short burst of bytes that is committed to the array when chip-select rises. Each commit starts an internal write cycle of a programmable number of system clocks. During that cycle the block raises a busy flag and accepts only the status-read command. A pause pin freezes a transfer in mid-flight. A write-protect pin, armed by a status bit, blocks status updates.

Top module: `spi_mem_slave`

## Requirements
- R1: Data-in is taken on rising serial-clock edges and data-out changes after falling edges. Both are most significant bit first, and the first read bit is on data-out before the first rising edge of the data byte.
- R2: The first byte after chip-select falls is the command. The valid codes are 0x06 set-latch, 0x04 clear-latch, 0x05 status read, 0x01 status write, 0x03 array read and 0x02 array write.
- R3: Any other command code makes the block ignore all further bits, with the data-out enable low, until chip-select falls again. The next transfer then works normally.
- R4: While chip-select is high, the data-out enable is low and serial-clock and data-in activity has no effect.
- R5: Pause pin low while the serial clock is low freezes the transfer. Clock edges are ignored and the data-out enable is low. Pause pin high while the serial clock is low resumes the same transfer where it stopped.
- R6: The status byte has bit 0 = busy, bit 1 = write-enable latch, bit 7 = protect-arm bit (WPEN), and all other bits are 0. Set-latch sets bit 1, clear-latch clears it, and the end of every write cycle clears it.
- R7: An array write or status write issued while the write-enable latch is clear changes nothing.
- R8: A read takes a 16-bit address, of which only the low ADDR_BITS bits are used. It returns consecutive bytes and wraps from the last array entry to entry 0.
- R9: An array write takes a 16-bit address and then data bytes. It is committed when chip-select rises, but only if at least one byte was received and no partial byte follows. Up to PAGE_BYTES bytes go to consecutive addresses that wrap at the array end, and extra bytes are discarded.
- R10: A commit makes writeBusy high for exactly WRITE_CYCLES clocks. During that time every command except status read is treated as invalid.
- R11: With WPEN = 1 and the write-protect pin low, status writes are refused. With WPEN = 0 the pin has no effect.
- R12: If the write-protect pin goes low while chip-select is low during an armed status write, that write is dropped even if the pin is high again by the time chip-select rises. Once the write cycle has started, the pin cannot change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample all pins |
| rstN | input | 1 | Active-low synchronous reset |
| csN | input | 1 | Chip-select, active low |
| sck | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data from the host |
| holdN | input | 1 | Pause request, active low |
| wpN | input | 1 | Write-protect pin, active low |
| so | output | 1 | Serial data to the host |
| soEn | output | 1 | Drive enable for so; low means the pad floats |
| writeBusy | output | 1 | High during an internal write cycle |

## Verification
The assertions check four properties on every cycle. The data-out enable never rises while the synchronised chip-select is high. A write cycle lasts exactly the programmed count and clears the latch when it ends. The protect bit neither changes while the block is busy nor gets updated past an armed, low write-protect pin. The transmit shift register also holds still through a pause. Other behaviours need whole transfers and can only be shown by the bench's scenarios: command decoding, address wrap, the whole-byte rule on commit, the burst limit, the lockout after a bad command, and resuming a read byte after a pause.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_ADDR,
    ST_READ,
    ST_STAT,
    ST_WRITE,
    ST_WRSR,
    ST_DRAIN
  } xferState_t;

  typedef struct packed {
    logic rxShift;
    logic addrShift;
    logic txLoadMem;
    logic txLoadStat;
    logic txShift;
    logic bufPush;
    logic srCapture;
    logic welSet;
    logic welClr;
    logic commitWrite;
    logic commitStatus;
  } ctrlStrobe_t;

endpackage

// File: rtl/spi_mem_sync.sv
module spi_mem_sync #(
  parameter int WIDTH = 5,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] pinIn,
  output logic [WIDTH-1:0] pinSync
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (!rstN) chain <= {STAGES{RESET_VAL[b]}};
      else       chain <= {chain[STAGES-2:0], pinIn[b]};
    end
    assign pinSync[b] = chain[STAGES-1];
  end

endmodule

// File: rtl/spi_mem_ctrl.sv
module spi_mem_ctrl
  import spi_mem_pkg::*;
#(
  parameter int PAGE_BYTES = 4,
  parameter int CNT_W = $clog2(PAGE_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csS,
  input  logic             sckS,
  input  logic             holdS,
  input  logic             wpS,
  input  logic [7:0]       rxNext,
  input  logic             busy,
  input  logic             wel,
  input  logic             wpen,
  output ctrlStrobe_t      strb,
  output logic [CNT_W-1:0] bufIdx,
  output logic             soEn,
  output logic             pausedQ
);

  xferState_t state;
  logic sckPrev, csPrev, isRead, txValid, srDone, wpAbort;
  logic [2:0] bitCnt;
  logic [3:0] addrCnt;
  logic [CNT_W-1:0] byteCnt;

  logic live, sckRise, sckFall, csRise, byteDone, opcDone, wpBlock, txPhase;

  assign live     = !csS && !pausedQ && (state != ST_IDLE);
  assign sckRise  = live && sckS && !sckPrev;
  assign sckFall  = live && !sckS && sckPrev;
  assign csRise   = csS && !csPrev;
  assign byteDone = sckRise && (bitCnt == 3'd7);
  assign opcDone  = byteDone && (state == ST_OPC);
  assign wpBlock  = wpen && !wpS;
  assign txPhase  = (state == ST_READ) || (state == ST_STAT);

  always_comb begin
    strb = '0;
    strb.rxShift      = sckRise;
    strb.addrShift    = sckRise && (state == ST_ADDR);
    strb.txLoadMem    = sckFall && (state == ST_READ) && (bitCnt == 3'd0);
    strb.txLoadStat   = sckFall && (state == ST_STAT) && (bitCnt == 3'd0);
    strb.txShift      = sckFall && txPhase && (bitCnt != 3'd0);
    strb.bufPush      = byteDone && (state == ST_WRITE) && (byteCnt < CNT_W'(PAGE_BYTES));
    strb.srCapture    = byteDone && (state == ST_WRSR);
    strb.welSet       = opcDone && (rxNext == OP_WREN) && !busy;
    strb.welClr       = opcDone && (rxNext == OP_WRDI) && !busy;
    strb.commitWrite  = csRise && (state == ST_WRITE) && (bitCnt == 3'd0)
                        && (byteCnt != '0) && wel && !busy;
    strb.commitStatus = csRise && srDone && (bitCnt == 3'd0) && !wpAbort
                        && !wpBlock && wel && !busy;
  end

  assign bufIdx = byteCnt;
  assign soEn   = !csS && !pausedQ && txValid && txPhase;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      sckPrev <= 1'b0;
      csPrev  <= 1'b1;
      pausedQ <= 1'b0;
      isRead  <= 1'b0;
      txValid <= 1'b0;
      srDone  <= 1'b0;
      wpAbort <= 1'b0;
      bitCnt  <= '0;
      addrCnt <= '0;
      byteCnt <= '0;
    end else begin
      sckPrev <= sckS;
      csPrev  <= csS;
      if (csS)        pausedQ <= 1'b0;
      else if (!sckS) pausedQ <= !holdS;

      if (csS) begin
        state   <= ST_IDLE;
        txValid <= 1'b0;
      end else if (state == ST_IDLE) begin
        state   <= ST_OPC;
        bitCnt  <= '0;
        addrCnt <= '0;
        byteCnt <= '0;
        srDone  <= 1'b0;
        wpAbort <= 1'b0;
        txValid <= 1'b0;
      end else begin
        if (wpBlock && ((state == ST_WRSR) || srDone)) wpAbort <= 1'b1;
        if (sckFall && txPhase) txValid <= 1'b1;
        if (sckRise) begin
          bitCnt <= bitCnt + 3'd1;
          unique case (state)
            ST_OPC: if (bitCnt == 3'd7) begin
              unique case (rxNext)
                OP_READ:  begin state <= busy ? ST_DRAIN : ST_ADDR; isRead <= 1'b1; end
                OP_WRITE: begin state <= busy ? ST_DRAIN : ST_ADDR; isRead <= 1'b0; end
                OP_RDSR:  state <= ST_STAT;
                OP_WRSR:  state <= busy ? ST_DRAIN : ST_WRSR;
                default:  state <= ST_DRAIN;
              endcase
            end
            ST_ADDR: begin
              addrCnt <= addrCnt + 4'd1;
              if (addrCnt == 4'd15) state <= isRead ? ST_READ : ST_WRITE;
            end
            ST_WRITE: if (strb.bufPush) byteCnt <= byteCnt + CNT_W'(1);
            ST_WRSR: if (bitCnt == 3'd7) begin
              srDone <= 1'b1;
              state  <= ST_DRAIN;
            end
            default: ;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/spi_mem_datapath.sv
module spi_mem_datapath
  import spi_mem_pkg::*;
#(
  parameter int ADDR_BITS = 6,
  parameter int PAGE_BYTES = 4,
  parameter int WRITE_CYCLES = 2000,
  parameter int CNT_W = $clog2(PAGE_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             siS,
  input  ctrlStrobe_t      strb,
  input  logic [CNT_W-1:0] bufIdx,
  output logic [7:0]       rxNext,
  output logic             soBit,
  output logic             busy,
  output logic             wel,
  output logic             wpen,
  output logic [7:0]       txByte
);

  localparam int DEPTH  = 1 << ADDR_BITS;
  localparam int IDX_W  = (PAGE_BYTES > 1) ? $clog2(PAGE_BYTES) : 1;
  localparam int BUSY_W = $clog2(WRITE_CYCLES + 1);

  logic [7:0] rxQ, txQ, srPend;
  logic [ADDR_BITS-1:0] addrIdx;
  logic [7:0] memArr [DEPTH];
  logic [7:0] bufArr [PAGE_BYTES];
  logic [BUSY_W-1:0] busyCnt;
  logic [7:0] statusByte;

  assign rxNext     = {rxQ[6:0], siS};
  assign busy       = (busyCnt != '0);
  assign statusByte = {wpen, 5'b00000, wel, busy};
  assign soBit      = txQ[7];
  assign txByte     = txQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxQ     <= '0;
      txQ     <= '0;
      srPend  <= '0;
      addrIdx <= '0;
    end else begin
      if (strb.rxShift)   rxQ <= rxNext;
      if (strb.addrShift) addrIdx <= {addrIdx[ADDR_BITS-2:0], siS};
      if (strb.txLoadMem) begin
        txQ     <= memArr[addrIdx];
        addrIdx <= addrIdx + ADDR_BITS'(1);
      end else if (strb.txLoadStat) begin
        txQ <= statusByte;
      end else if (strb.txShift) begin
        txQ <= {txQ[6:0], 1'b0};
      end
      if (strb.srCapture) srPend <= rxNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < PAGE_BYTES; i++) bufArr[i] <= '0;
    end else if (strb.bufPush) begin
      bufArr[bufIdx[IDX_W-1:0]] <= rxNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) memArr[i] <= '0;
    end else if (strb.commitWrite) begin
      for (int i = 0; i < PAGE_BYTES; i++)
        if (CNT_W'(i) < bufIdx) memArr[addrIdx + ADDR_BITS'(i)] <= bufArr[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wel     <= 1'b0;
      wpen    <= 1'b0;
      busyCnt <= '0;
    end else begin
      if (strb.commitWrite || strb.commitStatus) begin
        busyCnt <= BUSY_W'(WRITE_CYCLES);
        if (strb.commitStatus) wpen <= srPend[7];
      end else if (busy) begin
        busyCnt <= busyCnt - BUSY_W'(1);
        if (busyCnt == BUSY_W'(1)) wel <= 1'b0;
      end
      if (strb.welSet)      wel <= 1'b1;
      else if (strb.welClr) wel <= 1'b0;
    end
  end

endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave
  import spi_mem_pkg::*;
#(
  parameter int ADDR_BITS = 6,
  parameter int PAGE_BYTES = 4,
  parameter int WRITE_CYCLES = 2000
) (
  input  logic clk,
  input  logic rstN,
  input  logic csN,
  input  logic sck,
  input  logic si,
  input  logic holdN,
  input  logic wpN,
  output logic so,
  output logic soEn,
  output logic writeBusy
);

  localparam int SYNC_STAGES = 2;
  localparam int CNT_W = $clog2(PAGE_BYTES + 1);

  logic [4:0] pinSync;
  logic csS, sckS, siS, holdS, wpS;
  ctrlStrobe_t strb;
  logic [CNT_W-1:0] bufIdx;
  logic [7:0] rxNext, txByte;
  logic welQ, wpenQ, pausedQ;

  spi_mem_sync #(
    .WIDTH(5), .STAGES(SYNC_STAGES), .RESET_VAL(5'b11001)
  ) u_sync (
    .clk(clk), .rstN(rstN),
    .pinIn({csN, holdN, wpN, sck, si}),
    .pinSync(pinSync)
  );
  assign {csS, holdS, wpS, sckS, siS} = pinSync;

  spi_mem_ctrl #(.PAGE_BYTES(PAGE_BYTES), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .csS(csS), .sckS(sckS), .holdS(holdS),
    .wpS(wpS), .rxNext(rxNext), .busy(writeBusy), .wel(welQ),
    .wpen(wpenQ), .strb(strb), .bufIdx(bufIdx), .soEn(soEn),
    .pausedQ(pausedQ)
  );

  spi_mem_datapath #(
    .ADDR_BITS(ADDR_BITS), .PAGE_BYTES(PAGE_BYTES),
    .WRITE_CYCLES(WRITE_CYCLES), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .siS(siS), .strb(strb), .bufIdx(bufIdx),
    .rxNext(rxNext), .soBit(so), .busy(writeBusy), .wel(welQ),
    .wpen(wpenQ), .txByte(txByte)
  );

endmodule

// File: rtl/spi_mem_slave_chk.sv
module spi_mem_slave_chk #(
  parameter int WRITE_CYCLES = 2000
) (
  input logic       clk,
  input logic       rstN,
  input logic       csN,
  input logic       soEn,
  input logic       writeBusy,
  input logic       wel,
  input logic       wpen,
  input logic       wpS,
  input logic       paused,
  input logic [7:0] txByte
);

  int busyRun;
  always_ff @(posedge clk) begin
    if (!rstN)          busyRun <= 0;
    else if (writeBusy) busyRun <= busyRun + 1;
    else                busyRun <= 0;
  end

  // R4: pad only driven while the pin, two syncs earlier, was low
  p_so_float_cs_r4: assert property (@(posedge clk) disable iff (!rstN)
    soEn |-> !$past(csN, 2));

  // R10: write cycle length counted independently
  p_busy_len_r10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(writeBusy) |-> (busyRun == WRITE_CYCLES));

  // R6: latch cleared when the cycle ends
  p_wel_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(writeBusy) |-> !wel);

  // R11: protect bit only updated past an unarmed or high protect pin
  p_wp_gate_r11: assert property (@(posedge clk) disable iff (!rstN)
    (wpen != $past(wpen)) |-> ($past(wpS) || !$past(wpen)));

  // R12: status frozen once a cycle runs
  p_status_frozen_r12: assert property (@(posedge clk) disable iff (!rstN)
    (writeBusy && $past(writeBusy)) |-> $stable(wpen));

  // R5: transmit shifter frozen during a pause
  p_hold_freeze_r5: assert property (@(posedge clk) disable iff (!rstN)
    (paused && $past(paused)) |-> $stable(txByte));

endmodule

bind spi_mem_slave spi_mem_slave_chk #(.WRITE_CYCLES(WRITE_CYCLES)) u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .soEn(soEn), .writeBusy(writeBusy),
  .wel(welQ), .wpen(wpenQ), .wpS(wpS), .paused(pausedQ), .txByte(txByte)
);

// File: tb/spi_mem_slave_tb.sv
module spi_mem_slave_tb;

  localparam int ADDR_BITS = 6;
  localparam int PAGE = 4;
  localparam int CYC = 1200;
  localparam int HALF = 8;

  logic clk = 1'b0, rstN = 1'b0;
  logic csN = 1'b1, sck = 1'b0, si = 1'b0, holdN = 1'b1, wpN = 1'b1;
  logic so, soEn, writeBusy;
  int checks = 0, fails = 0;
  int busyLen = 0, lastBusyLen = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  spi_mem_slave #(.ADDR_BITS(ADDR_BITS), .PAGE_BYTES(PAGE), .WRITE_CYCLES(CYC)) u_dut (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .si(si), .holdN(holdN),
    .wpN(wpN), .so(so), .soEn(soEn), .writeBusy(writeBusy)
  );

  always @(negedge clk) begin
    if (writeBusy) busyLen <= busyLen + 1;
    else begin
      if (busyLen != 0) lastBusyLen <= busyLen;
      busyLen <= 0;
    end
  end

  // {write address, read address, data}
  localparam logic [39:0] VEC [6] = '{
    {16'h0003, 16'h0003, 8'hA5},
    {16'h0010, 16'h0010, 8'h5A},
    {16'h1047, 16'h0007, 8'hFF},
    {16'h003F, 16'hFFFF, 8'h81},
    {16'h0020, 16'h8020, 8'h00},
    {16'h0001, 16'h0001, 8'h7E}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic spiBit(input logic b, output logic r, inout logic en);
    si = b;
    repeat (HALF) @(negedge clk);
    r = so;
    en = en | soEn;
    sck = 1'b1;
    repeat (HALF) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic spiByte(input logic [7:0] tx, output logic [7:0] rx, inout logic en);
    for (int i = 7; i >= 0; i--) spiBit(tx[i], rx[i], en);
  endtask

  task automatic csStart();
    csN = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic csEnd();
    repeat (HALF) @(negedge clk);
    csN = 1'b1;
    repeat (2 * HALF) @(negedge clk);
  endtask

  task automatic cmd(input logic [7:0] op);
    logic [7:0] d; logic en = 1'b0;
    csStart(); spiByte(op, d, en); csEnd();
  endtask

  task automatic rdsr(output logic [7:0] st);
    logic [7:0] d; logic en = 1'b0;
    csStart(); spiByte(8'h05, d, en); spiByte(8'h00, st, en); csEnd();
  endtask

  task automatic waitIdle();
    while (writeBusy) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic writeMem(input logic [15:0] a, input int n, input logic [39:0] data);
    logic [7:0] d; logic en = 1'b0;
    csStart();
    spiByte(8'h02, d, en); spiByte(a[15:8], d, en); spiByte(a[7:0], d, en);
    for (int k = 0; k < n; k++) spiByte(data[8*(n-1-k) +: 8], d, en);
    csEnd();
  endtask

  task automatic readMem(input logic [15:0] a, input int n, output logic [63:0] data, output logic en);
    logic [7:0] d;
    en = 1'b0; data = '0;
    csStart();
    spiByte(8'h03, d, en); spiByte(a[15:8], d, en); spiByte(a[7:0], d, en);
    en = 1'b0;
    for (int k = 0; k < n; k++) begin
      spiByte(8'h00, d, en);
      data = {data[55:0], d};
    end
    csEnd();
  endtask

  initial begin
    logic [7:0] st, d;
    logic [63:0] rd;
    logic en;
    repeat (10) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    // R4 R6: reset state
    check("R4 soEn after reset", soEn, 0);
    check("R10 busy after reset", writeBusy, 0);
    rdsr(st);
    check("R6 status after reset", st, 8'h00);

    // R2 R8 R1: table of single-byte writes and readbacks
    for (int v = 0; v < 6; v++) begin
      cmd(8'h06);
      writeMem(VEC[v][39:24], 1, {32'h0, VEC[v][7:0]});
      waitIdle();
      readMem(VEC[v][23:8], 1, rd, en);
      check("R8 table readback", rd[7:0], VEC[v][7:0]);
    end

    // R9 R8: burst wrapping at the array end
    cmd(8'h06);
    writeMem(16'h003E, 3, 40'h0000112233);
    waitIdle();
    readMem(16'h003E, 3, rd, en);
    check("R9 wrap burst", rd[23:0], 24'h112233);

    // R9: bytes beyond the burst limit are dropped
    cmd(8'h06);
    writeMem(16'h0008, 5, 40'h0102030405);
    waitIdle();
    readMem(16'h0008, 5, rd, en);
    check("R9 burst limit", rd[39:0], 40'h0102030400);

    // R7: write with latch clear ignored
    writeMem(16'h0010, 1, 40'h99);
    repeat (10) @(negedge clk);
    check("R7 no busy without latch", writeBusy, 0);
    readMem(16'h0010, 1, rd, en);
    check("R7 array unchanged", rd[7:0], 8'h5A);

    // R6: set and clear latch
    cmd(8'h06); rdsr(st);
    check("R6 latch set", st, 8'h02);
    cmd(8'h04); rdsr(st);
    check("R6 latch cleared", st, 8'h00);

    // R9: partial trailing byte blocks the commit
    cmd(8'h06);
    en = 1'b0;
    csStart();
    spiByte(8'h02, d, en); spiByte(8'h00, d, en); spiByte(8'h03, d, en);
    spiByte(8'hEE, d, en);
    for (int b = 0; b < 3; b++) spiBit(1'b1, d[0], en);
    csEnd();
    check("R9 partial no busy", writeBusy, 0);
    readMem(16'h0003, 1, rd, en);
    check("R9 partial array unchanged", rd[7:0], 8'hA5);
    rdsr(st);
    check("R9 latch kept", st, 8'h02);
    cmd(8'h04);

    // R3: invalid code locks out until next select
    en = 1'b0;
    csStart();
    spiByte(8'hAB, d, en); spiByte(8'h05, d, en); spiByte(8'h00, d, en);
    csEnd();
    check("R3 lockout soEn", en, 0);
    rdsr(st);
    check("R3 recovers", st, 8'h00);

    // R10: busy window and command rejection
    cmd(8'h06);
    writeMem(16'h0020, 1, 40'h44);
    rdsr(st);
    check("R10 status during busy", st, 8'h03);
    readMem(16'h0020, 1, rd, en);
    check("R10 read rejected while busy", en, 0);
    waitIdle();
    check("R10 busy length", lastBusyLen, CYC);
    rdsr(st);
    check("R6 latch cleared by cycle end", st, 8'h00);
    readMem(16'h0020, 1, rd, en);
    check("R10 data committed", rd[7:0], 8'h44);

    // R4: clock and data while deselected are ignored (pattern 0x06)
    en = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      si = 8'h06 >> i;
      repeat (HALF) @(negedge clk);
      en = en | soEn;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
    check("R4 soEn deselected", en, 0);
    rdsr(st);
    check("R4 SI ignored", st, 8'h00);

    // R5 R1: pause in the middle of a read byte (address 1 holds 0x7E)
    en = 1'b0;
    csStart();
    spiByte(8'h03, d, en); spiByte(8'h00, d, en); spiByte(8'h01, d, en);
    for (int i = 7; i >= 4; i--) spiBit(1'b0, d[i], en);
    holdN = 1'b0;
    repeat (HALF) @(negedge clk);
    en = 1'b0;
    for (int t = 0; t < 3; t++) begin
      sck = 1'b1; si = 1'b1; repeat (HALF) @(negedge clk); en = en | soEn;
      sck = 1'b0; repeat (HALF) @(negedge clk); en = en | soEn;
    end
    check("R5 soEn during pause", en, 0);
    holdN = 1'b1;
    repeat (HALF) @(negedge clk);
    for (int i = 3; i >= 0; i--) spiBit(1'b0, d[i], en);
    csEnd();
    check("R5 byte intact across pause", d, 8'h7E);

    // R11 R12: protect arm and pin
    cmd(8'h06);
    en = 1'b0;
    csStart(); spiByte(8'h01, d, en); spiByte(8'h80, d, en); csEnd();
    waitIdle();
    rdsr(st);
    check("R11 arm bit written", st, 8'h80);
    wpN = 1'b0;
    cmd(8'h06);
    csStart(); spiByte(8'h01, d, en); spiByte(8'h00, d, en); csEnd();
    repeat (10) @(negedge clk);
    rdsr(st);
    check("R11 status write refused", st, 8'h82);
    wpN = 1'b1;
    csStart(); spiByte(8'h01, d, en); spiByte(8'h00, d, en);
    wpN = 1'b0; repeat (HALF) @(negedge clk); wpN = 1'b1;
    csEnd();
    repeat (10) @(negedge clk);
    rdsr(st);
    check("R12 pulse aborts write", st, 8'h82);
    csStart(); spiByte(8'h01, d, en); spiByte(8'h00, d, en); csEnd();
    waitIdle();
    rdsr(st);
    check("R11 unprotected write", st, 8'h00);
    wpN = 1'b0;
    cmd(8'h06);
    csStart(); spiByte(8'h01, d, en); spiByte(8'h80, d, en); csEnd();
    waitIdle();
    rdsr(st);
    check("R11 pin ignored when unarmed", st, 8'h80);
    wpN = 1'b1;
    cmd(8'h06);
    csStart(); spiByte(8'h01, d, en); spiByte(8'h00, d, en); csEnd();
    wpN = 1'b0;
    waitIdle();
    wpN = 1'b1;
    rdsr(st);
    check("R12 pin after cycle start", st, 8'h00);

    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (190000) @(negedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule